// File: doc/BRIEF.md
# Sequential Carry-Save Multioperand Accumulator

This block adds a fixed number of unsigned operands, one per clock cycle, and returns their sum modulo 2^OPW. All operands arrive together as one flat vector. A pulse on `start` launches a run. A step counter then walks the operand slices in order. Each slice is folded into a redundant running total that is kept as two registers: a sum word and a carry word. This stage has no carry chain, so the per-cycle logic depth does not grow with the operand width.

After the last slice has been absorbed, a single ripple carry-propagate adder merges the two words. The merged value is registered as the result, and `done` pulses for one cycle. The result then holds until the next run completes. The caller must keep the operand vector steady from the cycle in which it raises `start` until `done` is seen.

Top module: `csa_multiop_acc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `done` to 0 and `result` to 0 and drops any run in progress. The dropped run never raises `done`.
- R2: `result` equals the sum of all NOPS operands, truncated to OPW bits.
- R3: Operand j is taken from bits [j*OPW +: OPW] of `ops_flat`, for j = 0 to NOPS-1. Every slice contributes exactly once.
- R4: When `start` is sampled high while idle, `done` goes high NOPS+2 rising edges later, counting the edge that sampled `start` as the first. It stays high for exactly one cycle.
- R5: A `start` pulse raised while a run is in progress has no effect. The run's `done` timing and `result` are unchanged.
- R6: `result` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R7: Sums that exceed 2^OPW-1 wrap. For example, all-ones operands give NOPS*(2^OPW-1) mod 2^OPW.
- R8: A `start` raised in the cycle in which `done` is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a run when the block is idle |
| ops_flat | input | NOPS*OPW | Concatenated operands; slice j is operand j |
| result | output | OPW | Registered sum, modulo 2^OPW |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The assertions assume that `ops_flat` does not change from the cycle in which `start` is raised until `done` is seen. They also assume that reset is held low for at least two edges. The bench changes the operand vector only while the block is idle or exactly in the `done` cycle, and it always holds reset for several cycles. Stray `start` pulses are injected only in the middle of a run, which is where R5 says they must be ignored.

// File: rtl/csa_acc_pkg.sv
// Package: shared types for the carry-save multioperand accumulator.
// Assumes: nothing; holds only the run-phase encoding.
package csa_acc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_t;
endpackage

// File: rtl/csa_opsel.sv
// Module: csa_opsel
// Picks operand slice `sel` out of the flat operand vector.
// Assumes: slice j occupies bits [j*OPW +: OPW]; a select value of NOPS or above yields zero.
module csa_opsel #(
    parameter int OPW   = 8,
    parameter int NOPS  = 5,
    parameter int CNT_W = 3
) (
    input  logic [NOPS*OPW-1:0] ops_flat,
    input  logic [CNT_W-1:0]    sel,
    output logic [OPW-1:0]      operand
);
    logic [OPW-1:0] slice [NOPS];

    // Unpack the flat vector into one word per operand.
    for (genvar j = 0; j < NOPS; j++) begin : g_slice
        assign slice[j] = ops_flat[j*OPW +: OPW];
    end

    // Multiplex: choose the slice whose index matches sel.
    always_comb begin
        operand = '0;
        for (int j = 0; j < NOPS; j++) begin
            if (sel == CNT_W'(j)) operand = slice[j];
        end
    end
endmodule

// File: rtl/csa_row.sv
// Module: csa_row
// One row of OPW independent full adders (3-to-2 compressor).
// Outputs the unshifted per-bit sum and carry vectors.
// Assumes: the caller weights carry bit i at position i+1.
module csa_row #(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] in_a,
    input  logic [OPW-1:0] in_b,
    input  logic [OPW-1:0] in_c,
    output logic [OPW-1:0] bit_sum,
    output logic [OPW-1:0] bit_cy
);
    // Per-bit full adder: parity for the sum, majority for the carry.
    for (genvar i = 0; i < OPW; i++) begin : g_fa
        assign bit_sum[i] = in_a[i] ^ in_b[i] ^ in_c[i];
        assign bit_cy[i]  = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end

    // Arithmetic check of the compression: a+b+c == sum + 2*carry (supports R2).
    always_comb begin
        a_csa_value_r2: assert ((OPW+2)'(in_a) + (OPW+2)'(in_b) + (OPW+2)'(in_c)
                                == (OPW+2)'(bit_sum) + ((OPW+2)'(bit_cy) << 1));
    end
endmodule

// File: rtl/csa_cpa.sv
// Module: csa_cpa
// Ripple carry-propagate adder, modulo 2^OPW, with zero carry-in.
// Built from a propagate XOR and a carry mux per bit.
// Assumes: the carry out of the top bit is discarded.
module csa_cpa #(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] add_a,
    input  logic [OPW-1:0] add_b,
    output logic [OPW-1:0] add_sum
);
    logic [OPW:0] cy;

    assign cy[0] = 1'b0;

    // Per bit: pass the incoming carry when propagating, otherwise take a_i as generate.
    for (genvar i = 0; i < OPW; i++) begin : g_rip
        logic prop;
        assign prop       = add_a[i] ^ add_b[i];
        assign cy[i+1]    = prop ? cy[i] : add_a[i];
        assign add_sum[i] = prop ^ cy[i];
    end
endmodule

// File: rtl/csa_seq.sv
// Module: csa_seq
// Run sequencer: idle -> NOPS absorb steps -> one finish step -> idle.
// Assumes: start is honoured only in the idle phase; reset is synchronous and active low.
module csa_seq
    import csa_acc_pkg::*;
#(
    parameter int NOPS  = 5,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             clear,
    output logic             absorb,
    output logic             finish,
    output logic [CNT_W-1:0] step
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NOPS - 1);

    phase_t           ph_q;
    logic [CNT_W-1:0] cnt_q;

    assign clear  = (ph_q == PH_IDLE) && start;
    assign absorb = (ph_q == PH_RUN);
    assign finish = (ph_q == PH_FIN);
    assign step   = cnt_q;

    // Phase and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) ph_q <= PH_RUN;
                end
                PH_RUN: begin
                    if (cnt_q == LAST) begin
                        ph_q  <= PH_FIN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FIN:  ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R3: the step index never leaves the operand range.
    p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: mid-run steps always advance by one and stay running, whatever start does.
    p_run_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && cnt_q != LAST) |=> (ph_q == PH_RUN && cnt_q == $past(cnt_q) + 1'b1));

    // R4: the last absorb step is followed by the finish step.
    p_last_then_fin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && cnt_q == LAST) |=> (ph_q == PH_FIN));
endmodule

// File: rtl/csa_multiop_acc.sv
// Module: csa_multiop_acc (top)
// Sums NOPS unsigned OPW-bit operands, one per cycle, in stored-carry form.
// A single carry-propagate addition produces the registered result.
// Assumes: ops_flat is stable from start until done; OPW >= 2; NOPS >= 2.
module csa_multiop_acc
    import csa_acc_pkg::*;
#(
    parameter int OPW  = 8,
    parameter int NOPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NOPS*OPW-1:0] ops_flat,
    output logic [OPW-1:0]      result,
    output logic                done
);
    localparam int CNT_W = (NOPS > 1) ? $clog2(NOPS) : 1;

    logic             clear, absorb, finish;
    logic [CNT_W-1:0] step;
    logic [OPW-1:0]   operand;
    logic [OPW-1:0]   u_q, v_q;
    logic [OPW-1:0]   row_sum, row_cy;
    logic [OPW-1:0]   merged;
    logic [OPW-1:0]   result_q;
    logic             done_q;

    csa_seq #(.NOPS(NOPS), .CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .clear  (clear),
        .absorb (absorb),
        .finish (finish),
        .step   (step)
    );

    csa_opsel #(.OPW(OPW), .NOPS(NOPS), .CNT_W(CNT_W)) u_sel (
        .ops_flat (ops_flat),
        .sel      (step),
        .operand  (operand)
    );

    csa_row #(.OPW(OPW)) u_row (
        .in_a    (u_q),
        .in_b    (operand),
        .in_c    (v_q),
        .bit_sum (row_sum),
        .bit_cy  (row_cy)
    );

    csa_cpa #(.OPW(OPW)) u_cpa (
        .add_a   (u_q),
        .add_b   (v_q),
        .add_sum (merged)
    );

    // Redundant accumulator: zero on start; each step absorbs one operand.
    // The carry vector is shifted up one bit and the top carry is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
            v_q <= '0;
        end else if (clear) begin
            u_q <= '0;
            v_q <= '0;
        end else if (absorb) begin
            u_q <= row_sum;
            v_q <= {row_cy[OPW-2:0], 1'b0};
        end
    end

    // Output stage: capture the merged sum and pulse done on the finish step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) result_q <= merged;
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // R4: done is a single-cycle pulse.
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done follows the finish step.
    p_done_after_fin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);

    // R6: result moves only in a cycle where done is raised.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(result));

    // R2: an accepted start leaves a zeroed accumulator.
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (u_q == '0 && v_q == '0));

    // R2: the stored carry word never holds a bit in position zero.
    p_carry_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[0] == 1'b0);
endmodule

// File: tb/tb_csa_multiop_acc.sv
module tb_csa_multiop_acc;
    localparam int OPW  = 8;
    localparam int NOPS = 5;
    localparam int W    = OPW * NOPS;
    localparam int NVEC = 6;

    localparam logic [W-1:0] VECS [NVEC] = '{
        40'h00_00_00_00_00,
        40'h01_02_03_04_05,
        40'hFF_FF_FF_FF_FF,
        40'h80_80_00_00_00,
        40'h12_34_56_78_9A,
        40'hAA_55_AA_55_01
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   ops_flat = '0;
    logic [OPW-1:0] result;
    logic           done;

    int n_chk = 0;
    int n_bad = 0;

    csa_multiop_acc #(.OPW(OPW), .NOPS(NOPS)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ops_flat (ops_flat),
        .result   (result),
        .done     (done)
    );

    always #5 clk = ~clk;

    function automatic logic [OPW-1:0] ref_sum(input logic [W-1:0] v);
        logic [OPW-1:0] acc = '0;
        for (int j = 0; j < NOPS; j++) acc = acc + v[j*OPW +: OPW];
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller sits at a negedge. Launches a run and follows it edge by edge.
    task automatic run_op(input logic [W-1:0] vec, input bit poke, input bit chain, input string tag);
        logic [OPW-1:0] exp;
        bit             tim_ok;
        int             first_hi;
        int             lim;
        exp      = ref_sum(vec);
        tim_ok   = 1'b1;
        first_hi = -1;
        lim      = chain ? NOPS + 2 : NOPS + 3;
        ops_flat = vec;
        start    = 1'b1;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            start = poke && (k == 2 || k == 3);   // R5: stray start mid-run
            if (done && first_hi < 0) first_hi = k;
            if (done != (k == NOPS + 2)) tim_ok = 1'b0;
            if (k == NOPS + 2) chk(result == exp, tag, result, exp);
            if (k == NOPS + 3) chk(result == exp, "R6", result, exp);
        end
        chk(tim_ok, poke ? "R5" : "R4", first_hi, NOPS + 2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", done, 0);
        chk(result == '0, "R1", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk (R2, R4, R6; the all-ones row checks R7 wrap)
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i], 1'b0, 1'b0, (VECS[i] == '1) ? "R7" : "R2");
        end

        // R3: one nonzero slice at a time
        for (int j = 0; j < NOPS; j++) begin
            logic [W-1:0] v;
            v = '0;
            v[j*OPW +: OPW] = OPW'(8'h11 * (j + 1));
            run_op(v, 1'b0, 1'b0, "R3");
        end

        // R5: start pulses during a run are ignored
        run_op(40'h10_20_30_40_50, 1'b1, 1'b0, "R5");

        // R8: back-to-back, with start raised in the done cycle
        run_op(40'h01_01_01_01_01, 1'b0, 1'b1, "R8");
        run_op(40'h07_07_07_07_F0, 1'b0, 1'b0, "R8");

        // R1: reset in the middle of a run drops it
        ops_flat = 40'h33_33_33_33_33;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(result == '0, "R1", result, 0);
        rst_n = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < NOPS + 4; k++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, "R1", seen, 0);
            chk(result == '0, "R1", result, 0);
        end

        // R2: the block still works after the aborted run
        run_op(40'hC8_64_32_19_0A, 1'b0, 1'b0, "R2");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule